// File: doc/BRIEF.md
# Byte-Lane Burst Synchronous SRAM

This block is a synthesizable storage model of a synchronous burst SRAM. Its default depth is 256 words, and each word is split into four byte lanes. A bus cycle is decoded from three chip enables, two address strobes, an advance input, a global write enable, a byte-write enable and four per-lane byte strobes.

- **Processor strobe.** A cycle opened by the processor strobe always starts as a read.
- **Controller strobe.** A cycle opened by the controller strobe samples the write controls on its opening edge.
- **Burst.** After a cycle is opened, a two-bit burst counter walks the four words of an aligned group. The count order is interleaved (XOR) or linear (add, wrapping within four), chosen by a static pin.

Read data leaves through a registered path. In pipelined mode there is one extra stage. In flow-through mode that stage is bypassed. The tristate bus is replaced by a data output and a valid flag. The valid flag has no ready partner: there is no back-pressure. A consumer must take `rdata` in every cycle in which `rvalid` is high, because the next edge may replace it. Output enable and the sleep input act on `rvalid` without waiting for a clock. While sleep is high, clock edges change nothing.

Top module: `burst_sram`

## Requirements
- R1: When `gwe_n` is low on an edge that writes, all four lanes of the accessed word take `wdata`.
- R2: When `gwe_n` is high and `bwe_n` is low, only lanes whose `bs_n` bit is low are written; lane i maps to `wdata[8i+7:8i]` and `bs_n[i]`. If no `bs_n` bit is low, the access is a read.
- R3: When `gwe_n` and `bwe_n` are both high, the access is a read and no lane changes.
- R4: An edge with `pstb_n` low and `ce_main_n` low opens a read at `addr`, whatever `gwe_n`, `bwe_n`, `bs_n` and `cstb_n` are. On that edge `bs_n` does not suppress the output.
- R5: An edge with `cstb_n` low opens a cycle at `addr` only when the processor strobe is not accepted on it. The write controls sampled on that edge decide between read and write.
- R6: `ce_main_n` high stops the processor strobe but not the controller strobe. On any edge where an accepted strobe sees `ce_main_n` high, `ce_hi` low or `ce_lo_n` high, the device is deselected, and `rvalid` is low from the next cycle.
- R7: On a continuation edge (selected, no strobe), `adv_n` low moves to the next burst word and `adv_n` high repeats the current one. The access on that edge uses the resulting address. The low two address bits are the start offset combined with a count of 0..3: XOR when `seq_linear`=0, addition modulo 4 when `seq_linear`=1. The upper bits never change within a burst.
- R8: With `flow_n` high (pipelined), data read on edge k is presented after edge k+1. It is dropped if edge k+1 writes or deselects.
- R9: With `flow_n` low (flow-through), data read on edge k is presented right after edge k.
- R10: `oe_n` high forces `rvalid` low at once. A `bs_n` value with any bit low, sampled on an edge other than a processor-strobe opening, forces `rvalid` low until the next edge.
- R11: While `sleep` is high, edges are ignored: stored words, burst position and output state are kept, and `rvalid` is low.
- R12: After reset the device is deselected with `rvalid` low; `rdata` is zero whenever `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of control state (not of stored words) |
| addr | input | 8 | Word address, loaded on an opening edge |
| wdata | input | 32 | Write data, four byte lanes |
| ce_main_n | input | 1 | Master chip enable, active low; stops the processor strobe |
| ce_hi | input | 1 | Chip enable, active high |
| ce_lo_n | input | 1 | Chip enable, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bs_n | input | 4 | Per-lane byte strobes, active low |
| oe_n | input | 1 | Output enable, active low, unclocked |
| flow_n | input | 1 | Static mode: 1 pipelined, 0 flow-through |
| seq_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Sleep: ignore edges, keep contents |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench aims at the following corner cases, each paired with the fault it would expose:

- **Processor strobe with write enables low.** A design that wrote here, or let `bs_n` blank the output, would corrupt memory or drop the read.
- **Master enable high.** A design that let it deselect a processor-strobe edge would lose the ongoing burst.
- **Both burst orders from mid-group start offsets.** A wrong wrap would read a neighbour word.
- **Pipelined read followed at once by a write or deselect.** A missing turnaround rule would present stale data.
- **Sleep with writes attempted.** A leaky sleep gate would alter contents or the burst position, which the later read-back exposes.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int BURST_W = 2;
  localparam int BURST_LEN = 1 << BURST_W;

  function automatic logic [BURST_W-1:0] burst_offset(
      input logic [BURST_W-1:0] start,
      input logic [BURST_W-1:0] count,
      input logic linear);
    return linear ? start + count : start ^ count;
  endfunction
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode #(
  parameter int LANES = 4
) (
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             ce_main_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bs_n,
  input  logic             sleep,
  input  logic             selected,
  output logic             load,
  output logic             desel,
  output logic             cont,
  output logic             pstart,
  output logic [LANES-1:0] wr_lanes,
  output logic             bs_hit
);
  logic active, strobe, en_ok;
  logic [LANES-1:0] lanes_dec;

  always_comb begin
    active    = !sleep;
    pstart    = !pstb_n && !ce_main_n;
    strobe    = pstart || !cstb_n;
    en_ok     = !ce_main_n && ce_hi && !ce_lo_n;
    load      = active && strobe && en_ok;
    desel     = active && strobe && !en_ok;
    cont      = active && !strobe && selected;
    if (!gwe_n)      lanes_dec = '1;
    else if (!bwe_n) lanes_dec = ~bs_n;
    else             lanes_dec = '0;
    wr_lanes  = ((load && !pstart) || cont) ? lanes_dec : '0;
    bs_hit    = active && !pstart && (bs_n != '1);
  end

  // R4: a processor-strobe opening never carries a write
  always_comb begin
    if (load && pstart) assert (wr_lanes == '0) else $error("a_r4_pstart_read");
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] ld_addr,
  output logic [AW-1:0] acc_addr
);
  import sram_pkg::*;

  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nx;
  logic [AW-1:0]      base_nx;

  always_comb begin
    base_nx  = load ? ld_addr : base_q;
    cnt_nx   = load ? '0 : (step ? cnt_q + 1'b1 : cnt_q);
    acc_addr = {base_nx[AW-1:BURST_W], burst_offset(base_nx[BURST_W-1:0], cnt_nx, linear)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load || step) begin
      base_q <= base_nx;
      cnt_q  <= cnt_nx;
    end
  end

  a_r7_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q));
  a_r11_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] wr_lanes,
  input  logic             rd,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lanes[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd)          q[g*LANE_W +: LANE_W] <= cells[addr];
    end
  end
endmodule

// File: rtl/sram_read_path.sv
module sram_read_path #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flow_n,
  input  logic          oe_n,
  input  logic          sleep,
  input  logic          rd,
  input  logic          wr_any,
  input  logic          desel,
  input  logic          bs_hit,
  input  logic [DW-1:0] q_in,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          s1_q, s2_q, bs_off_q;
  logic [DW-1:0] q2_q;
  logic          stage_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      bs_off_q <= 1'b0;
    end else if (!sleep) begin
      s1_q     <= rd;
      s2_q     <= s1_q && !wr_any && !desel;
      bs_off_q <= bs_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep) q2_q <= q_in;
  end

  always_comb begin
    stage_v = flow_n ? s2_q : s1_q;
    rvalid  = stage_v && !oe_n && !sleep && !bs_off_q;
    rdata   = rvalid ? (flow_n ? q2_q : q_in) : '0;
  end

  a_r8_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s2_q) |-> $past(s1_q));
  a_r11_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(s1_q) && $stable(s2_q) && $stable(bs_off_q)));
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             ce_main_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             adv_n,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bs_n,
  input  logic             oe_n,
  input  logic             flow_n,
  input  logic             seq_linear,
  input  logic             sleep,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  logic             load, desel, cont, pstart, bs_hit;
  logic [LANES-1:0] wr_lanes;
  logic             selected_q, rd, wr_any;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    arr_q;

  sram_cycle_decode #(.LANES(LANES)) u_dec (
    .pstb_n(pstb_n), .cstb_n(cstb_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .bs_n(bs_n),
    .sleep(sleep), .selected(selected_q), .load(load), .desel(desel),
    .cont(cont), .pstart(pstart), .wr_lanes(wr_lanes), .bs_hit(bs_hit));

  always_comb begin
    wr_any = |wr_lanes;
    rd     = (load || cont) && !wr_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     selected_q <= 1'b0;
    else if (load)  selected_q <= 1'b1;
    else if (desel) selected_q <= 1'b0;
  end

  sram_burst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(cont && !adv_n),
    .linear(seq_linear), .ld_addr(addr), .acc_addr(acc_addr));

  sram_byte_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .addr(acc_addr), .wr_lanes(wr_lanes), .rd(rd),
    .wdata(wdata), .q(arr_q));

  sram_read_path #(.DW(DW)) u_rp (
    .clk(clk), .rst_n(rst_n), .flow_n(flow_n), .oe_n(oe_n), .sleep(sleep),
    .rd(rd), .wr_any(wr_any), .desel(desel), .bs_hit(bs_hit),
    .q_in(arr_q), .rdata(rdata), .rvalid(rvalid));

  a_r6_desel_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cstb_n && (ce_main_n || !ce_hi || ce_lo_n)) |=> !rvalid);
  a_r10_strobe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !(!pstb_n && !ce_main_n) && bs_n != '1) |=> !rvalid);
  a_r12_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
  a_r11_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> wr_lanes == '0);
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic ce_main_n, ce_hi, ce_lo_n, pstb_n, cstb_n, adv_n, gwe_n, bwe_n;
  logic [3:0] bs_n;
  logic oe_n, flow_n = 1'b1, seq_linear = 1'b0, sleep;
  logic [31:0] rdata;
  logic rvalid;

  int checks = 0, fails = 0;

  // bench reference state
  logic [31:0] ref_mem [256];
  logic        m_sel, m_s1, m_s2, m_bsoff;
  logic [7:0]  m_base;
  logic [1:0]  m_cnt;
  logic [31:0] m_q1, m_q2;

  burst_sram uut (.*);

  always #2ns clk = ~clk;

  initial begin
    #800us;
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [31:0] pat(input int i);
    return 32'h9E37_79B9 * (i + 1) ^ 32'h5A5A_0000;
  endfunction

  task automatic defaults();
    ce_main_n = 0; ce_hi = 1; ce_lo_n = 0; pstb_n = 1; cstb_n = 1;
    adv_n = 1; gwe_n = 1; bwe_n = 1; bs_n = 4'hF; oe_n = 0; sleep = 0;
  endtask

  task automatic model_edge();
    logic pst, stb, ok, acc;
    logic [3:0] lanes;
    logic [7:0] a;
    if (sleep) return;
    pst = !pstb_n && !ce_main_n;
    stb = pst || !cstb_n;
    ok  = !ce_main_n && ce_hi && !ce_lo_n;
    lanes = !gwe_n ? 4'hF : (!bwe_n ? ~bs_n : 4'h0);
    acc = 0;
    if (stb && ok) begin
      m_sel = 1; m_base = addr; m_cnt = 0; acc = 1;
      if (pst) lanes = 0;
    end else if (stb) m_sel = 0;
    else if (m_sel) begin
      if (!adv_n) m_cnt = m_cnt + 1;
      acc = 1;
    end
    if (!acc) lanes = 0;
    a = {m_base[7:2], seq_linear ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt};
    m_s2 = m_s1 && lanes == 0 && !(stb && !ok);
    m_q2 = m_q1;
    m_s1 = acc && lanes == 0;
    if (m_s1) m_q1 = ref_mem[a];
    for (int i = 0; i < 4; i++) if (lanes[i]) ref_mem[a][i*8 +: 8] = wdata[i*8 +: 8];
    m_bsoff = !pst && (bs_n != 4'hF);
  endtask

  task automatic check_out(input string tag);
    logic ev;
    logic [31:0] ed;
    ev = (flow_n ? m_s2 : m_s1) && !oe_n && !sleep && !m_bsoff;
    ed = ev ? (flow_n ? m_q2 : m_q1) : 32'h0;
    checks++;
    if (rvalid !== ev || rdata !== ed) begin
      fails++;
      $display("FAIL %s: rvalid/rdata actual %b/%h expected %b/%h", tag, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out(tag);
    defaults();
  endtask

  task automatic do_reset();
    @(negedge clk);
    defaults(); rst_n = 0;
    m_sel = 0; m_s1 = 0; m_s2 = 0; m_bsoff = 0; m_base = 0; m_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cwrite(input logic [7:0] a, input logic g, input logic b,
                        input logic [3:0] s, input logic [31:0] d, input string tag);
    cstb_n = 0; addr = a; gwe_n = g; bwe_n = b; bs_n = s; wdata = d;
    step(tag);
  endtask

  task automatic pread(input logic [7:0] a, input string tag);
    pstb_n = 0; addr = a;
    step(tag);
  endtask

  task automatic cont(input logic adv, input string tag);
    adv_n = adv;
    step(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    defaults();
    do_reset();
    // R12: state straight out of reset
    checks++;
    if (rvalid !== 1'b0 || rdata !== 32'h0) begin
      fails++;
      $display("FAIL R12: rvalid/rdata actual %b/%h expected 0/0", rvalid, rdata);
    end
    step("R12");

    // R1: fill every word with a global write
    for (int i = 0; i < 256; i++) cwrite(i[7:0], 0, 1, 4'hF, pat(i), "R1");

    // R8: pipelined reads, then turnaround into a write
    flow_n = 1'b1; do_reset();
    pread(8'h10, "R8"); cont(1, "R8"); cont(0, "R8"); cont(0, "R8");
    cwrite(8'h20, 0, 1, 4'hF, 32'hCAFE_F00D, "R8"); step("R8");
    pread(8'h20, "R1"); cont(1, "R1"); cont(1, "R1");

    // R2: partial lanes, and byte write with no lane selected
    cwrite(8'h31, 1, 0, 4'b1010, 32'h1122_3344, "R2");
    cwrite(8'h32, 1, 0, 4'hF, 32'hDEAD_BEEF, "R2");
    cont(1, "R2"); cont(1, "R2");
    pread(8'h31, "R2"); cont(1, "R2"); pread(8'h32, "R2"); cont(1, "R2"); cont(1, "R2");

    // R3: both write enables high reads only
    cwrite(8'h33, 1, 1, 4'hF, 32'h0BAD_0BAD, "R3"); cont(1, "R3"); cont(1, "R3");

    // R4: processor strobe wins and ignores writes and strobes
    pstb_n = 0; cstb_n = 0; addr = 8'h40; gwe_n = 0; bs_n = 4'h0; wdata = 32'hFFFF_FFFF;
    step("R4"); cont(1, "R4"); cont(1, "R4");
    // R5: processor-opened cycle writes on a continuation edge
    pread(8'h41, "R5"); gwe_n = 0; wdata = 32'h5555_AAAA; step("R5");
    pread(8'h41, "R5"); cont(1, "R5"); cont(1, "R5");

    // R6: master enable high blocks processor strobe; other enables deselect
    pread(8'h50, "R6"); ce_main_n = 1; pstb_n = 0; addr = 8'h60; step("R6"); cont(1, "R6");
    cstb_n = 0; ce_lo_n = 1; step("R6"); step("R6"); step("R6");
    cstb_n = 0; ce_main_n = 1; step("R6"); step("R6");
    pread(8'h50, "R6"); cstb_n = 0; ce_hi = 0; step("R6"); step("R6");

    // R7: both burst orders from mid-group offsets
    for (int o = 0; o < 2; o++) begin
      seq_linear = o[0];
      pread(8'h72, "R7"); cont(0, "R7"); cont(0, "R7"); cont(0, "R7"); cont(0, "R7"); cont(1, "R7");
      cwrite(8'h87, 0, 1, 4'hF, 32'h0000_0001, "R7");
      gwe_n = 0; adv_n = 0; wdata = 32'h0000_0002; step("R7");
      gwe_n = 0; adv_n = 0; wdata = 32'h0000_0003; step("R7");
      pread(8'h84, "R7"); cont(0, "R7"); cont(0, "R7"); cont(0, "R7"); cont(1, "R7");
    end

    // R9: flow-through latency and turnaround
    flow_n = 1'b0; do_reset();
    pread(8'h10, "R9"); cont(0, "R9"); cont(0, "R9");
    cwrite(8'h11, 1, 0, 4'b0111, 32'hAB00_0000, "R9"); pread(8'h11, "R9"); cont(1, "R9");

    // R10: output enable and byte strobe blanking
    pread(8'h12, "R10"); oe_n = 1; step("R10"); step("R10");
    bs_n = 4'b1110; step("R10"); step("R10");
    flow_n = 1'b1; do_reset();
    pread(8'h13, "R10"); bs_n = 4'b0111; step("R10"); step("R10"); step("R10");

    // R11: sleep ignores edges and keeps contents and burst position
    pread(8'h14, "R11"); cont(0, "R11");
    sleep = 1; cstb_n = 0; addr = 8'h15; gwe_n = 0; wdata = 32'h0; step("R11");
    sleep = 1; gwe_n = 0; adv_n = 0; step("R11");
    cont(0, "R11"); cont(1, "R11");
    pread(8'h15, "R11"); cont(1, "R11"); cont(1, "R11");

    // mixed random traffic in both modes and both orders
    for (int m = 0; m < 4; m++) begin
      flow_n = m[0]; seq_linear = m[1];
      do_reset();
      for (int n = 0; n < 1500; n++) begin
        addr = 8'($urandom);
        wdata = $urandom;
        ce_main_n = ($urandom % 10) == 0;
        ce_hi = ($urandom % 20) != 0;
        ce_lo_n = ($urandom % 20) == 0;
        pstb_n = ($urandom % 6) != 0;
        cstb_n = ($urandom % 6) != 0;
        adv_n = 1'($urandom);
        gwe_n = ($urandom % 7) != 0;
        bwe_n = ($urandom % 3) != 0;
        bs_n = ($urandom % 2) ? 4'hF : 4'($urandom);
        oe_n = ($urandom % 10) == 0;
        sleep = ($urandom % 20) == 0;
        step("mix");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule